// File: doc/BRIEF.md
# Predicated Integer ALU with Condition Flags

This block executes the data-processing class of a 32-bit load/store processor in one stage. Each cycle it takes a 4-bit condition code, a 4-bit operation code, a flag-update bit, the destination register index, the first source value, the already shifted second operand with its shifter carry, the current N/Z/C/V flags, the current privilege mode and the saved status word. One clock later it presents the result, a register write enable, the flags the core should hold next, and a request to reload the status word from its saved copy.

The instruction runs only when its condition code holds against the incoming flags. If flag update is requested, the destination is the program counter (index 15) and the core is in a privileged mode that owns a saved status word, no flags are computed. The block instead raises the reload request and passes the saved word's flag nibble through as the next flags. The register file, the shifter, mode switching and the other instruction classes sit around this block.

Top module: `palu_top`

## Requirements
- R1: Condition codes decode as follows, with flags given as N,Z,C,V: 0 Z set; 1 Z clear; 2 C set; 3 C clear; 4 N set; 5 N clear; 6 V set; 7 V clear; 8 C set and Z clear; 9 C clear or Z set; 10 N equal to V; 11 N not equal to V; 12 Z clear and N equal to V; 13 Z set or N not equal to V; 14 always. The instruction executes only when its code holds.
- R2: Condition code 15 never executes. Any instruction that does not execute leaves the write enable and the reload request low and returns the incoming flags unchanged.
- R3: Operation codes are 0 AND, 1 EOR, 2 SUB (Rn-op), 3 RSB (op-Rn), 4 ADD, 5 ADC (+C), 6 SBC (Rn-op-!C), 7 RSC (op-Rn-!C), 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV (op), 14 BIC (Rn AND NOT op), 15 MVN (NOT op). The twelve writing operations that execute produce that result with the write enable high.
- R4: TST, TEQ, CMP and CMN (codes 8 to 11) never assert the write enable.
- R5: With the flag-update bit clear, the next flags equal the incoming flags and no reload is requested.
- R6: Flag-setting logical operations (AND, EOR, TST, TEQ, ORR, MOV, BIC, MVN) set N to result bit 31, Z when the result is zero, C to the shifter carry, and keep V.
- R7: Flag-setting additions (ADD, ADC, CMN) set C to the carry out of the full unsigned sum including the carry-in, and V when both operands share a sign that the result does not.
- R8: Flag-setting subtractions (SUB, RSB, SBC, RSC, CMP) set C when the minuend is at least the subtrahend plus the borrow as unsigned values, and V when the exact signed difference does not fit in 32 bits; N and Z follow the result.
- R9: When an executing instruction has the flag-update bit set, destination index 15 and a mode other than user (0x10) or system (0x1F), the reload request is high, the next flags are bits 31..28 of the saved word (N,Z,C,V), the status output carries the saved word, and a writing operation still writes its result. Otherwise the status output is zero.
- R10: All outputs are registered: they reflect the inputs of the previous rising edge, and a synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 4 | Condition code |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Flag-update request |
| rd_idx_i | input | RIDX_W | Destination register index |
| rn_val_i | input | DATA_W | First source value |
| opnd_i | input | DATA_W | Shifted second operand |
| shift_carry_i | input | 1 | Carry out of the shifter |
| flags_i | input | 4 | Current flags, N in bit 3 down to V in bit 0 |
| mode_i | input | MODE_W | Current privilege mode |
| saved_status_i | input | DATA_W | Saved status word |
| result_o | output | DATA_W | Operation result |
| reg_we_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Next flags, N in bit 3 down to V in bit 0 |
| restore_o | output | 1 | Reload status word from saved copy |
| status_o | output | DATA_W | Saved word to reload while restore_o is high |

## Verification
The bench builds the block with its defaults: a 32-bit datapath, a 4-bit register index and a 5-bit mode field with user 0x10 and system 0x1F. At this width the signed and unsigned boundaries (0x7FFFFFFF, 0x80000000, 0xFFFFFFFF) are easy to reach, and each of the sixteen condition codes can be swept against all sixteen flag patterns. The program-counter index comes up often enough that random stimulus reaches the reload path in both privileged and unprivileged modes. Borrow-chain cases such as SBC with an all-ones operand and no incoming carry are aimed at directly.

// File: rtl/palu_pkg.sv
package palu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_ZS = 4'd0,  CC_ZC = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_NS = 4'd4,  CC_NC = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_UHI = 4'd8, CC_ULS = 4'd9, CC_SGE = 4'd10, CC_SLT = 4'd11,
    CC_SGT = 4'd12, CC_SLE = 4'd13, CC_ALL = 4'd14, CC_NONE = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/palu_cond.sv
module palu_cond
  import palu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  nzcv_t      fl_i,
  output logic       pass_o
);
  logic sgn_eq;
  assign sgn_eq = (fl_i.n == fl_i.v);

  always_comb begin
    unique case (cond_e'(cond_i))
      CC_ZS:   pass_o = fl_i.z;
      CC_ZC:   pass_o = !fl_i.z;
      CC_CS:   pass_o = fl_i.c;
      CC_CC:   pass_o = !fl_i.c;
      CC_NS:   pass_o = fl_i.n;
      CC_NC:   pass_o = !fl_i.n;
      CC_VS:   pass_o = fl_i.v;
      CC_VC:   pass_o = !fl_i.v;
      CC_UHI:  pass_o = fl_i.c && !fl_i.z;
      CC_ULS:  pass_o = !fl_i.c || fl_i.z;
      CC_SGE:  pass_o = sgn_eq;
      CC_SLT:  pass_o = !sgn_eq;
      CC_SGT:  pass_o = !fl_i.z && sgn_eq;
      CC_SLE:  pass_o = fl_i.z || !sgn_eq;
      CC_ALL:  pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/palu_datapath.sv
module palu_datapath
  import palu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] rn_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              sh_carry_i,
  input  nzcv_t             fl_i,
  output logic [DATA_W-1:0] result_o,
  output logic              writes_o,
  output nzcv_t             fl_o
);
  localparam int MSB = DATA_W - 1;

  logic              is_arith;
  logic [DATA_W-1:0] add_a, add_b, logic_res;
  logic              add_cin;
  logic [DATA_W:0]   sum;
  logic              ovf;

  // All arithmetic maps onto a + b + cin; subtraction inverts b and uses
  // the carry-in as the "no borrow" term.
  always_comb begin
    is_arith  = 1'b1;
    add_a     = rn_i;
    add_b     = opnd_i;
    add_cin   = 1'b0;
    logic_res = '0;
    unique case (alu_op_e'(op_i))
      OP_SUB, OP_CMP: begin add_b = ~opnd_i; add_cin = 1'b1; end
      OP_SBC:         begin add_b = ~opnd_i; add_cin = fl_i.c; end
      OP_RSB:         begin add_a = opnd_i; add_b = ~rn_i; add_cin = 1'b1; end
      OP_RSC:         begin add_a = opnd_i; add_b = ~rn_i; add_cin = fl_i.c; end
      OP_ADD, OP_CMN: add_cin = 1'b0;
      OP_ADC:         add_cin = fl_i.c;
      OP_AND, OP_TST: begin is_arith = 1'b0; logic_res = rn_i & opnd_i; end
      OP_EOR, OP_TEQ: begin is_arith = 1'b0; logic_res = rn_i ^ opnd_i; end
      OP_ORR:         begin is_arith = 1'b0; logic_res = rn_i | opnd_i; end
      OP_MOV:         begin is_arith = 1'b0; logic_res = opnd_i; end
      OP_BIC:         begin is_arith = 1'b0; logic_res = rn_i & ~opnd_i; end
      default:        begin is_arith = 1'b0; logic_res = ~opnd_i; end
    endcase
  end

  assign sum      = {1'b0, add_a} + {1'b0, add_b} + {{DATA_W{1'b0}}, add_cin};
  assign ovf      = (add_a[MSB] == add_b[MSB]) && (sum[MSB] != add_a[MSB]);
  assign result_o = is_arith ? sum[MSB:0] : logic_res;
  assign writes_o = (op_i[3:2] != 2'b10);

  always_comb begin
    fl_o.n = result_o[MSB];
    fl_o.z = (result_o == '0);
    fl_o.c = is_arith ? sum[DATA_W] : sh_carry_i;
    fl_o.v = is_arith ? ovf : fl_i.v;
  end
endmodule

// File: rtl/palu_restore.sv
module palu_restore #(
  parameter int                RIDX_W    = 4,
  parameter int                MODE_W    = 5,
  parameter int                PC_INDEX  = 15,
  parameter logic [MODE_W-1:0] USER_MODE = 'h10,
  parameter logic [MODE_W-1:0] SYS_MODE  = 'h1F
) (
  input  logic              set_flags_i,
  input  logic [RIDX_W-1:0] rd_idx_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              hit_o
);
  localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(PC_INDEX);

  logic has_saved;
  assign has_saved = (mode_i != USER_MODE) && (mode_i != SYS_MODE);
  assign hit_o     = set_flags_i && (rd_idx_i == PC_IDX) && has_saved;
endmodule

// File: rtl/palu_top.sv
module palu_top
  import palu_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                RIDX_W    = 4,
  parameter int                MODE_W    = 5,
  parameter int                PC_INDEX  = 15,
  parameter logic [MODE_W-1:0] USER_MODE = 'h10,
  parameter logic [MODE_W-1:0] SYS_MODE  = 'h1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        op_i,
  input  logic              set_flags_i,
  input  logic [RIDX_W-1:0] rd_idx_i,
  input  logic [DATA_W-1:0] rn_val_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              shift_carry_i,
  input  logic [3:0]        flags_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DATA_W-1:0] saved_status_i,
  output logic [DATA_W-1:0] result_o,
  output logic              reg_we_o,
  output logic [3:0]        flags_o,
  output logic              restore_o,
  output logic [DATA_W-1:0] status_o
);
  localparam int FLAG_TOP = DATA_W - 1;

  nzcv_t             cur_fl, alu_fl;
  logic              pass, writes, hit, do_restore;
  logic [DATA_W-1:0] alu_res;
  logic [3:0]        next_fl;

  assign cur_fl = nzcv_t'(flags_i);

  palu_cond u_cond (
    .cond_i (cond_i),
    .fl_i   (cur_fl),
    .pass_o (pass)
  );

  palu_datapath #(.DATA_W(DATA_W)) u_dp (
    .op_i       (op_i),
    .rn_i       (rn_val_i),
    .opnd_i     (opnd_i),
    .sh_carry_i (shift_carry_i),
    .fl_i       (cur_fl),
    .result_o   (alu_res),
    .writes_o   (writes),
    .fl_o       (alu_fl)
  );

  palu_restore #(
    .RIDX_W(RIDX_W), .MODE_W(MODE_W), .PC_INDEX(PC_INDEX),
    .USER_MODE(USER_MODE), .SYS_MODE(SYS_MODE)
  ) u_rst (
    .set_flags_i (set_flags_i),
    .rd_idx_i    (rd_idx_i),
    .mode_i      (mode_i),
    .hit_o       (hit)
  );

  assign do_restore = pass && hit;

  always_comb begin
    if (!pass || !set_flags_i) next_fl = flags_i;
    else if (hit)              next_fl = saved_status_i[FLAG_TOP -: 4];
    else                       next_fl = alu_fl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      reg_we_o  <= 1'b0;
      flags_o   <= '0;
      restore_o <= 1'b0;
      status_o  <= '0;
    end else begin
      result_o  <= alu_res;
      reg_we_o  <= pass && writes;
      flags_o   <= next_fl;
      restore_o <= do_restore;
      status_o  <= do_restore ? saved_status_i : '0;
    end
  end
endmodule

// File: rtl/palu_checker.sv
module palu_checker #(
  parameter int                DATA_W    = 32,
  parameter int                RIDX_W    = 4,
  parameter int                MODE_W    = 5,
  parameter int                PC_INDEX  = 15,
  parameter logic [MODE_W-1:0] USER_MODE = 'h10,
  parameter logic [MODE_W-1:0] SYS_MODE  = 'h1F
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cond_i,
  input logic [3:0]        op_i,
  input logic              set_flags_i,
  input logic [RIDX_W-1:0] rd_idx_i,
  input logic [3:0]        flags_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [DATA_W-1:0] saved_status_i,
  input logic              reg_we_o,
  input logic [3:0]        flags_o,
  input logic              restore_o
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  logic is_logical;
  assign is_logical = (op_i inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15});

  a_r2_never_quiet: assert property (@(posedge clk) disable iff (rst)
    seen && $past(cond_i == 4'hF) |-> !reg_we_o && !restore_o && flags_o == $past(flags_i));

  a_r4_compare_no_write: assert property (@(posedge clk) disable iff (rst)
    seen && $past(op_i[3:2] == 2'b10) |-> !reg_we_o);

  a_r5_no_s_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    seen && $past(!set_flags_i) |-> flags_o == $past(flags_i) && !restore_o);

  a_r6_logical_keeps_v: assert property (@(posedge clk) disable iff (rst)
    seen && $past(is_logical && cond_i == 4'hE && rd_idx_i != RIDX_W'(PC_INDEX))
      |-> flags_o[0] == $past(flags_i[0]));

  a_r9_restore_source: assert property (@(posedge clk) disable iff (rst)
    seen && restore_o |-> $past(set_flags_i && rd_idx_i == RIDX_W'(PC_INDEX)
                                && mode_i != USER_MODE && mode_i != SYS_MODE));

  a_r9_restore_flags: assert property (@(posedge clk) disable iff (rst)
    seen && restore_o |-> flags_o == $past(saved_status_i[DATA_W-1 -: 4]));
endmodule

bind palu_top palu_checker #(
  .DATA_W(DATA_W), .RIDX_W(RIDX_W), .MODE_W(MODE_W), .PC_INDEX(PC_INDEX),
  .USER_MODE(USER_MODE), .SYS_MODE(SYS_MODE)
) u_chk (
  .clk(clk), .rst(rst), .cond_i(cond_i), .op_i(op_i), .set_flags_i(set_flags_i),
  .rd_idx_i(rd_idx_i), .flags_i(flags_i), .mode_i(mode_i),
  .saved_status_i(saved_status_i), .reg_we_o(reg_we_o), .flags_o(flags_o),
  .restore_o(restore_o)
);

// File: tb/tb_palu_top.sv
module tb_palu_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic [3:0]   cond_i, op_i, flags_i;
  logic         set_flags_i, shift_carry_i;
  logic [3:0]   rd_idx_i;
  logic [W-1:0] rn_val_i, opnd_i, saved_status_i;
  logic [4:0]   mode_i;
  logic [W-1:0] result_o, status_o;
  logic         reg_we_o, restore_o;
  logic [3:0]   flags_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  palu_top dut (
    .clk(clk), .rst(rst), .cond_i(cond_i), .op_i(op_i), .set_flags_i(set_flags_i),
    .rd_idx_i(rd_idx_i), .rn_val_i(rn_val_i), .opnd_i(opnd_i),
    .shift_carry_i(shift_carry_i), .flags_i(flags_i), .mode_i(mode_i),
    .saved_status_i(saved_status_i), .result_o(result_o), .reg_we_o(reg_we_o),
    .flags_o(flags_o), .restore_o(restore_o), .status_o(status_o)
  );

  typedef struct packed {
    logic [W-1:0] res;
    logic         we;
    logic [3:0]   fl;
    logic         rs;
    logic [W-1:0] st;
  } exp_t;

  function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      0: return z;            1: return !z;
      2: return cy;           3: return !cy;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return cy & !z;      9: return !cy | z;
      10: return n == v;      11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic fits32(input longint x);
    return (x <= 64'sd2147483647) && (x >= -64'sd2147483648);
  endfunction

  function automatic exp_t model(input logic [3:0] c, input logic [3:0] op, input logic s,
                                 input logic [3:0] rd, input logic [W-1:0] rn,
                                 input logic [W-1:0] b, input logic shc, input logic [3:0] f,
                                 input logic [4:0] md, input logic [W-1:0] sv);
    exp_t e;
    logic [W-1:0] r, m, sb;
    logic [63:0] big;
    longint sr;
    logic cy, v, br, cin;
    int kind; // 0 logical, 1 add, 2 sub
    e = '0;
    e.fl = f;
    cy = shc; v = f[0]; kind = 0; r = '0;
    m = rn; sb = b; br = 1'b0; cin = 1'b0;
    case (op)
      0, 8:  r = rn & b;
      1, 9:  r = rn ^ b;
      12:    r = rn | b;
      13:    r = b;
      14:    r = rn & ~b;
      15:    r = ~b;
      4, 11: kind = 1;
      5:     begin kind = 1; cin = f[1]; end
      2, 10: kind = 2;
      3:     begin kind = 2; m = b; sb = rn; end
      6:     begin kind = 2; br = !f[1]; end
      default: begin kind = 2; m = b; sb = rn; br = !f[1]; end
    endcase
    if (kind == 1) begin
      big = {32'b0, rn} + {32'b0, b} + {63'b0, cin};
      r = big[31:0]; cy = big[32];
      sr = longint'($signed(rn)) + longint'($signed(b)) + longint'(cin);
      v = !fits32(sr);
    end else if (kind == 2) begin
      r = m - sb - {31'b0, br};
      cy = ({32'b0, m} >= ({32'b0, sb} + {63'b0, br}));
      sr = longint'($signed(m)) - longint'($signed(sb)) - longint'(br);
      v = !fits32(sr);
    end
    e.res = r;
    if (!cond_ok(c, f)) return e;
    e.we = !(op >= 8 && op <= 11);
    if (s) begin
      if (rd == 4'd15 && md != 5'h10 && md != 5'h1F) begin
        e.rs = 1'b1; e.st = sv; e.fl = sv[31:28];
      end else begin
        e.fl = {r[31], r == 0, cy, v};
      end
    end
    return e;
  endfunction

  task automatic check(input string tag, input exp_t e);
    logic bad;
    checks++;
    bad = (reg_we_o !== e.we) || (flags_o !== e.fl) || (restore_o !== e.rs) ||
          (status_o !== e.st) || (e.we && result_o !== e.res);
    if (bad) begin
      errors++;
      $display("FAIL %s: actual we=%0b fl=%h rs=%0b st=%h res=%h expected we=%0b fl=%h rs=%0b st=%h res=%h",
               tag, reg_we_o, flags_o, restore_o, status_o, result_o,
               e.we, e.fl, e.rs, e.st, e.res);
    end
  endtask

  task automatic run(input string tag, input logic [3:0] c, input logic [3:0] op,
                     input logic s, input logic [3:0] rd, input logic [W-1:0] rn,
                     input logic [W-1:0] b, input logic shc, input logic [3:0] f,
                     input logic [4:0] md, input logic [W-1:0] sv);
    exp_t e;
    cond_i = c; op_i = op; set_flags_i = s; rd_idx_i = rd; rn_val_i = rn; opnd_i = b;
    shift_carry_i = shc; flags_i = f; mode_i = md; saved_status_i = sv;
    e = model(c, op, s, rd, rn, b, shc, f, md, sv);
    @(posedge clk);
    @(negedge clk);
    check(tag, e);
  endtask

  function automatic string tag_of(input logic [3:0] c, input logic [3:0] op, input logic s,
                                   input logic [3:0] rd, input logic [3:0] f, input logic [4:0] md);
    if (!cond_ok(c, f)) return "R2";
    if (s && rd == 15 && md != 5'h10 && md != 5'h1F) return "R9";
    if (op >= 8 && op <= 11 && !s) return "R4";
    if (!s) return "R5";
    if (op inside {4'd4, 4'd5, 4'd11}) return "R7";
    if (op inside {4'd2, 4'd3, 4'd6, 4'd7, 4'd10}) return "R8";
    return "R6";
  endfunction

  function automatic logic [W-1:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cond_i = 0; op_i = 0; set_flags_i = 0; rd_idx_i = 0; rn_val_i = 0; opnd_i = 0;
    shift_carry_i = 0; flags_i = 4'hF; mode_i = 5'h13; saved_status_i = '1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset clears all outputs
    checks++;
    if (result_o !== '0 || reg_we_o !== 0 || flags_o !== 0 || restore_o !== 0 || status_o !== '0) begin
      errors++;
      $display("FAIL R10: actual we=%0b fl=%h rs=%0b expected all zero", reg_we_o, flags_o, restore_o);
    end
    rst = 1'b0;

    // R1 / R2: sweep every condition against every flag pattern
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        run(c == 15 ? "R2" : "R1", 4'(c), 4'd13, 1'b0, 4'd1, 32'h0,
            32'(c * 16 + f), 1'b0, 4'(f), 5'h10, 32'h0);

    // R3: every opcode result with S clear
    for (int op = 0; op < 16; op++)
      run((op >= 8 && op <= 11) ? "R4" : "R3", 4'd14, 4'(op), 1'b0, 4'd2,
          32'hF0F0_1234, 32'h0FF0_0011, 1'b1, 4'b0010, 5'h10, 32'h0);

    // R7: additions
    run("R7", 4'd14, 4'd4, 1'b1, 4'd3, 32'h7FFF_FFFF, 32'h1, 1'b0, 4'h0, 5'h10, 32'h0);
    run("R7", 4'd14, 4'd5, 1'b1, 4'd3, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'b0010, 5'h10, 32'h0);
    run("R7", 4'd14, 4'd11, 1'b1, 4'd3, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'h0, 5'h10, 32'h0);
    // R8: subtractions and borrow corners
    run("R8", 4'd14, 4'd2, 1'b1, 4'd4, 32'h0, 32'h1, 1'b0, 4'h0, 5'h10, 32'h0);
    run("R8", 4'd14, 4'd10, 1'b1, 4'd4, 32'h55, 32'h55, 1'b0, 4'h0, 5'h10, 32'h0);
    run("R8", 4'd14, 4'd6, 1'b1, 4'd4, 32'h5, 32'hFFFF_FFFF, 1'b0, 4'h0, 5'h10, 32'h0);
    run("R8", 4'd14, 4'd3, 1'b1, 4'd4, 32'h1, 32'h8000_0000, 1'b0, 4'h0, 5'h10, 32'h0);
    run("R8", 4'd14, 4'd7, 1'b1, 4'd4, 32'h0, 32'h0, 1'b0, 4'h0, 5'h10, 32'h0);
    // R6: logical flags, V kept, C from shifter
    run("R6", 4'd14, 4'd0, 1'b1, 4'd5, 32'hF000_0000, 32'h0F00_0000, 1'b1, 4'b0001, 5'h10, 32'h0);
    run("R6", 4'd14, 4'd15, 1'b1, 4'd5, 32'h0, 32'h0, 1'b0, 4'b0011, 5'h1F, 32'h0);
    // R9: restore in privileged mode, none in user or system
    run("R9", 4'd14, 4'd4, 1'b1, 4'd15, 32'h10, 32'h20, 1'b0, 4'h0, 5'h13, 32'hA000_00D3);
    run("R9", 4'd14, 4'd10, 1'b1, 4'd15, 32'h1, 32'h1, 1'b0, 4'h0, 5'h11, 32'h5000_0011);
    run("R9", 4'd14, 4'd4, 1'b1, 4'd15, 32'h10, 32'h20, 1'b0, 4'h0, 5'h10, 32'hA000_00D3);
    run("R9", 4'd14, 4'd4, 1'b1, 4'd15, 32'h10, 32'h20, 1'b0, 4'h0, 5'h1F, 32'hA000_00D3);
    run("R9", 4'd0, 4'd4, 1'b1, 4'd15, 32'h10, 32'h20, 1'b0, 4'h0, 5'h13, 32'hA000_00D3);

    // R10: outputs hold until the next rising edge
    run("R10", 4'd14, 4'd13, 1'b0, 4'd6, 32'h0, 32'hCAFE_0001, 1'b0, 4'h0, 5'h10, 32'h0);
    opnd_i = 32'h1234_5678; op_i = 4'd8;
    #1;
    checks++;
    if (result_o !== 32'hCAFE_0001 || reg_we_o !== 1'b1) begin
      errors++;
      $display("FAIL R10: actual res=%h we=%0b expected res=cafe0001 we=1", result_o, reg_we_o);
    end

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c, op, rd, f;
      logic s;
      logic [4:0] md;
      c  = ($urandom_range(0, 3) == 0) ? 4'd14 : 4'($urandom_range(0, 15));
      op = 4'($urandom_range(0, 15));
      s  = 1'($urandom_range(0, 1));
      rd = ($urandom_range(0, 3) == 0) ? 4'd15 : 4'($urandom_range(0, 15));
      f  = 4'($urandom_range(0, 15));
      case ($urandom_range(0, 6))
        0: md = 5'h10; 1: md = 5'h11; 2: md = 5'h12; 3: md = 5'h13;
        4: md = 5'h17; 5: md = 5'h1B; default: md = 5'h1F;
      endcase
      run(tag_of(c, op, s, rd, f, md), c, op, s, rd, pick_val(), pick_val(),
          1'($urandom_range(0, 1)), f, md, $urandom());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule